// File: doc/BRIEF.md
# Quadrature Pulse Counter with Flutter Handling

The block counts transitions on two already-debounced digital channels (channel 0 on `ch_i[0]`, channel 1 on `ch_i[1]`). A 2-bit mode selects one of four regimes: off, one channel, two independent channels, or quadrature decoding of the pair.

In quadrature the block keeps a direction flag and a short shift history of step directions. It also runs a flutter detector, which spots a back-and-forth toggle. During flutter the block can either freeze both counters or fall back to two-channel counting until the motion settles. Each counter is compared with its own threshold.

Eight sticky event flags record what happened. Each flag has an enable, and the enabled flags are ORed into one interrupt request. Software clears the flags by pulsing write-one-to-clear bits.

Top module: `quad_pulse_counter`

## Requirements
- R1: `mode_i` encodes 0 = off, 1 = single, 2 = dual, 3 = quadrature. In off mode both counters hold and no flag is set, whatever the channels do.
- R2: In single mode counter 0 adds one for each rising edge of channel 0, and counter 1 holds.
- R3: In dual mode counter 0 adds one for each rising edge of channel 0, and counter 1 adds one for each rising edge of channel 1.
- R4: `state_o` is the phase of the sampled levels {ch1,ch0}: 00→0, 01→1, 11→2, 10→3. In quadrature a single-channel change is a step. A phase increment of one (mod 4) is clockwise and adds one to counter 0. Any other step is counter-clockwise and adds one to counter 1. `dir_o` takes the step direction (1 = clockwise, reset 0). Flag bit 0 is set when a step's direction differs from `dir_o`.
- R5: Each quadrature step shifts its direction into `dir_hist_o` at bit 0. Older entries move toward the MSB, and the history resets to 0.
- R6: In quadrature, a sample where both channels changed sets flag bit 5 and changes neither counter, direction nor history.
- R7: Flutter is tracked only in quadrature. It starts on a step whose direction differs from the previous step, when that previous step also differed from the one before it and at least two steps have been taken since quadrature was entered. Its start sets flag bit 7. It ends on a step in the same direction as the previous step, which sets flag bit 6. `flutter_o` shows the state. Leaving quadrature clears flutter and the step tally without setting a flag.
- R8: While flutter is active with `flut_stop_en_i` = 1, both counters hold. This takes priority over R9.
- R9: While flutter is active with `flut_dual_en_i` = 1 and no stop, counting follows dual-mode rules (except on a both-changed sample). Quadrature counting resumes once flutter ends.
- R10: Counters are `CNT_W` bits (default 24). An increment from all ones wraps to 0 and sets flag bit 1.
- R11: Flag bit 2 (bit 3) is set when counter 0 (counter 1) steps onto `cmp0_i` (`cmp1_i`).
- R12: In any mode but off, a sample where either channel changed sets flag bit 4.
- R13: Flags are sticky. A 1 on `flag_clr_i` bit n clears flag n, but a set in the same cycle wins. `irq_o` is the OR over n of `flags_o[n] & irq_en_i[n]`.
- R14: `lvl_o` is the channel sample taken at each edge and `lvl_prev_o` is the sample before it. Counters, flags, direction and flutter respond at the edge after the change is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Counting mode |
| flut_stop_en_i | input | 1 | Freeze counters during flutter |
| flut_dual_en_i | input | 1 | Dual-channel fallback during flutter |
| ch_i | input | 2 | Debounced channel levels |
| cmp0_i | input | CNT_W | Compare value for counter 0 |
| cmp1_i | input | CNT_W | Compare value for counter 1 |
| irq_en_i | input | 8 | Per-flag interrupt enables |
| flag_clr_i | input | 8 | Write-one-to-clear pulses |
| cnt0_o | output | CNT_W | Counter 0 |
| cnt1_o | output | CNT_W | Counter 1 |
| flags_o | output | 8 | Sticky event flags |
| state_o | output | 2 | Quadrature phase of sampled levels |
| lvl_o | output | 2 | Current sampled levels |
| lvl_prev_o | output | 2 | Previous sampled levels |
| dir_o | output | 1 | Last step direction, 1 = clockwise |
| dir_hist_o | output | HIST_W | Direction history, bit 0 newest |
| flutter_o | output | 1 | Flutter active |
| irq_o | output | 1 | Interrupt request |

## Verification
Some internal errors surface on the next step. A stale previous sample shows as a wrong count one edge after the change is sampled. A wrong phase decode shows as the wrong counter advancing, or as a spurious direction-change flag on that same step.

Other errors need a sequence of steps before they are visible. A wrong step tally or history tap only shows as flutter starting or ending on the wrong step, which needs three or four steps. A wrong wrap surfaces only after a full counter span, so overflow is exercised with a narrow counter.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int NFLAG = 8;
  localparam int NCNT  = 2;

  typedef enum logic [1:0] {
    MD_OFF    = 2'd0,
    MD_SINGLE = 2'd1,
    MD_DUAL   = 2'd2,
    MD_QUAD   = 2'd3
  } mode_e;

  localparam int F_DIRCHG = 0;
  localparam int F_WRAP   = 1;
  localparam int F_HIT0   = 2;
  localparam int F_HIT1   = 3;
  localparam int F_TRANS  = 4;
  localparam int F_QERR   = 5;
  localparam int F_FLEND  = 6;
  localparam int F_FLBEG  = 7;
endpackage

// File: rtl/qpc_sampler.sv
module qpc_sampler #(
  parameter int CH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CH-1:0] lvl_i,
  output logic [CH-1:0] cur_o,
  output logic [CH-1:0] prev_o,
  output logic [CH-1:0] chg_o,
  output logic [CH-1:0] rise_o
);
  logic [CH-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= lvl_i;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
  assign chg_o  = cur_q ^ prev_q;
  assign rise_o = cur_q & ~prev_q;
endmodule

// File: rtl/qpc_tracker.sv
module qpc_tracker #(
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        cur_i,
  input  logic [1:0]        prev_i,
  output logic [1:0]        phase_o,
  output logic              step_o,
  output logic              cw_o,
  output logic              qerr_o,
  output logic              dir_chg_o,
  output logic              fl_start_o,
  output logic              fl_end_o,
  output logic              dir_o,
  output logic [HIST_W-1:0] hist_o,
  output logic              flutter_o
);
  function automatic logic [1:0] phase_of(input logic [1:0] l);
    unique case (l)
      2'b00:   phase_of = 2'd0;
      2'b01:   phase_of = 2'd1;
      2'b11:   phase_of = 2'd2;
      default: phase_of = 2'd3;
    endcase
  endfunction

  logic [1:0]        chg;
  logic [1:0]        tally_q;
  logic              dir_q, flut_q, past_vld_q;
  logic [HIST_W-1:0] hist_q;

  assign chg        = cur_i ^ prev_i;
  assign phase_o    = phase_of(cur_i);
  assign step_o     = en_i && (chg == 2'b01 || chg == 2'b10);
  assign qerr_o     = en_i && (chg == 2'b11);
  assign cw_o       = phase_of(cur_i) == phase_of(prev_i) + 2'd1;
  assign dir_chg_o  = step_o && (cw_o != dir_q);
  assign fl_start_o = step_o && !flut_q && (tally_q == 2'd2) &&
                      (cw_o != hist_q[0]) && (hist_q[0] != hist_q[1]);
  assign fl_end_o   = step_o && flut_q && (cw_o == hist_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q      <= 1'b0;
      hist_q     <= '0;
      tally_q    <= '0;
      flut_q     <= 1'b0;
      past_vld_q <= 1'b0;
    end else begin
      past_vld_q <= 1'b1;
      if (!en_i) begin
        tally_q <= '0;
        flut_q  <= 1'b0;
      end else if (step_o) begin
        dir_q   <= cw_o;
        hist_q  <= {hist_q[HIST_W-2:0], cw_o};
        tally_q <= (tally_q == 2'd2) ? 2'd2 : tally_q + 2'd1;
        if (fl_start_o)    flut_q <= 1'b1;
        else if (fl_end_o) flut_q <= 1'b0;
      end
    end
  end

  assign dir_o     = dir_q;
  assign hist_o    = hist_q;
  assign flutter_o = flut_q;

  AST_FLUT_RISE_ON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && $rose(flut_q)) |-> $past(step_o)); // R7
  AST_QERR_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qerr_o |=> ($stable(dir_q) && $stable(hist_q))); // R6
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, nxt;
  logic         past_vld_q;

  assign nxt    = cnt_q + 1'b1;
  assign wrap_o = inc_i && (&cnt_q);
  assign hit_o  = inc_i && (nxt == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      past_vld_q <= 1'b0;
    end else begin
      past_vld_q <= 1'b1;
      if (inc_i) cnt_q <= nxt;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R10
endmodule

// File: rtl/qpc_flags.sv
module qpc_flags #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_q & ~clr_i)) |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i))); // R13
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R13
endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              flut_stop_en_i,
  input  logic              flut_dual_en_i,
  input  logic [1:0]        ch_i,
  input  logic [CNT_W-1:0]  cmp0_i,
  input  logic [CNT_W-1:0]  cmp1_i,
  input  logic [NFLAG-1:0]  irq_en_i,
  input  logic [NFLAG-1:0]  flag_clr_i,
  output logic [CNT_W-1:0]  cnt0_o,
  output logic [CNT_W-1:0]  cnt1_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic [1:0]        state_o,
  output logic [1:0]        lvl_o,
  output logic [1:0]        lvl_prev_o,
  output logic              dir_o,
  output logic [HIST_W-1:0] dir_hist_o,
  output logic              flutter_o,
  output logic              irq_o
);
  mode_e                        mode;
  logic [1:0]                   cur, prev, chg, rise;
  logic                         step, cw, qerr, dir_chg, fl_start, fl_end, flut;
  logic                         hold, fallback;
  logic [NCNT-1:0]              inc, wrap, hit;
  logic [NCNT-1:0][CNT_W-1:0]   cmp_v, cnt_v;
  logic [NFLAG-1:0]             set_v;

  assign mode = mode_e'(mode_i);

  qpc_sampler #(.CH(2)) u_sampler (
    .clk_i, .rst_ni, .lvl_i(ch_i),
    .cur_o(cur), .prev_o(prev), .chg_o(chg), .rise_o(rise)
  );

  qpc_tracker #(.HIST_W(HIST_W)) u_tracker (
    .clk_i, .rst_ni,
    .en_i(mode == MD_QUAD),
    .cur_i(cur), .prev_i(prev),
    .phase_o(state_o), .step_o(step), .cw_o(cw), .qerr_o(qerr),
    .dir_chg_o(dir_chg), .fl_start_o(fl_start), .fl_end_o(fl_end),
    .dir_o(dir_o), .hist_o(dir_hist_o), .flutter_o(flut)
  );

  assign hold     = (mode == MD_OFF) || (mode == MD_QUAD && flut && flut_stop_en_i);
  assign fallback = (mode == MD_QUAD) && flut && flut_dual_en_i;

  always_comb begin
    inc = '0;
    if (!hold) begin
      unique case (mode)
        MD_SINGLE: inc[0] = rise[0];
        MD_DUAL:   inc    = rise;
        MD_QUAD: begin
          if (fallback) inc = qerr ? 2'b00 : rise;
          else          inc = {step & ~cw, step & cw};
        end
        default:   inc = '0;
      endcase
    end
  end

  assign cmp_v[0] = cmp0_i;
  assign cmp_v[1] = cmp1_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    qpc_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i(inc[g]), .cmp_i(cmp_v[g]),
      .cnt_o(cnt_v[g]), .wrap_o(wrap[g]), .hit_o(hit[g])
    );
  end

  always_comb begin
    set_v           = '0;
    set_v[F_DIRCHG] = dir_chg;
    set_v[F_WRAP]   = |wrap;
    set_v[F_HIT0]   = hit[0];
    set_v[F_HIT1]   = hit[1];
    set_v[F_TRANS]  = (mode != MD_OFF) && (|chg);
    set_v[F_QERR]   = qerr;
    set_v[F_FLEND]  = fl_end;
    set_v[F_FLBEG]  = fl_start;
  end

  qpc_flags #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni,
    .set_i(set_v), .clr_i(flag_clr_i), .en_i(irq_en_i),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  assign cnt0_o     = cnt_v[0];
  assign cnt1_o     = cnt_v[1];
  assign lvl_o      = cur;
  assign lvl_prev_o = prev;
  assign flutter_o  = flut;

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> ($stable(cnt0_o) && $stable(cnt1_o))); // R1
  AST_QERR_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && lvl_o == ~lvl_prev_o) |=> ($stable(cnt0_o) && $stable(cnt1_o))); // R6
  AST_FLUT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && flutter_o && flut_stop_en_i) |=> ($stable(cnt0_o) && $stable(cnt1_o))); // R8
  AST_SINGLE_CNT1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |=> $stable(cnt1_o)); // R2
endmodule

// File: tb/quad_pulse_counter_bench.sv
module quad_pulse_counter_bench;
  localparam int TB_W = 10;
  localparam int HW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic            stop_en = 1'b0, dual_en = 1'b0;
  logic [1:0]      ch = 2'b00;
  logic [TB_W-1:0] cmp0 = '0, cmp1 = '0;
  logic [7:0]      en = 8'h00, clr = 8'h00;
  logic [TB_W-1:0] cnt0, cnt1;
  logic [7:0]      flags;
  logic [1:0]      state, lvl, lvl_prev;
  logic            dir, flut, irq;
  logic [HW-1:0]   hist;

  always #5 clk = ~clk;

  quad_pulse_counter #(.CNT_W(TB_W), .HIST_W(HW)) u_quad_pulse_counter (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .flut_stop_en_i(stop_en), .flut_dual_en_i(dual_en),
    .ch_i(ch), .cmp0_i(cmp0), .cmp1_i(cmp1),
    .irq_en_i(en), .flag_clr_i(clr),
    .cnt0_o(cnt0), .cnt1_o(cnt1), .flags_o(flags), .state_o(state),
    .lvl_o(lvl), .lvl_prev_o(lvl_prev), .dir_o(dir), .dir_hist_o(hist),
    .flutter_o(flut), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [TB_W-1:0] m_c0 = '0, m_c1 = '0;
  logic [7:0]      m_flags = '0;
  logic            m_dir = 1'b0, m_flut = 1'b0;
  logic [HW-1:0]   m_hist = '0;
  int              m_tally = 0;
  logic [1:0]      m_lv = 2'b00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ph(input logic [1:0] l);
    case (l)
      2'b00: ph = 2'd0;
      2'b01: ph = 2'd1;
      2'b11: ph = 2'd2;
      default: ph = 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] lv_of(input logic [1:0] p);
    case (p)
      2'd0: lv_of = 2'b00;
      2'd1: lv_of = 2'b01;
      2'd2: lv_of = 2'b11;
      default: lv_of = 2'b10;
    endcase
  endfunction

  task automatic m_inc(input int idx, inout logic [7:0] s);
    if (idx == 0) begin
      if (m_c0 == '1) s[1] = 1'b1;
      m_c0 = m_c0 + 1'b1;
      if (m_c0 == cmp0) s[2] = 1'b1;
    end else begin
      if (m_c1 == '1) s[1] = 1'b1;
      m_c1 = m_c1 + 1'b1;
      if (m_c1 == cmp1) s[3] = 1'b1;
    end
  endtask

  task automatic model(input logic [1:0] nl, input logic [7:0] cmask);
    logic [1:0] chg, rise;
    logic [7:0] s;
    logic cw, fs, fe;
    chg = nl ^ m_lv;
    rise = nl & ~m_lv;
    s = '0;
    if (mode != 2'd0 && chg != 2'b00) s[4] = 1'b1;
    case (mode)
      2'd1: if (rise[0]) m_inc(0, s);
      2'd2: begin
        if (rise[0]) m_inc(0, s);
        if (rise[1]) m_inc(1, s);
      end
      2'd3: begin
        if (chg == 2'b11) s[5] = 1'b1;
        else if (chg != 2'b00) begin
          cw = ph(nl) == ph(m_lv) + 2'd1;
          if (cw != m_dir) s[0] = 1'b1;
          fs = !m_flut && m_tally >= 2 && cw != m_hist[0] && m_hist[0] != m_hist[1];
          fe = m_flut && cw == m_hist[0];
          if (m_flut && stop_en) begin
          end else if (m_flut && dual_en) begin
            if (rise[0]) m_inc(0, s);
            if (rise[1]) m_inc(1, s);
          end else if (cw) m_inc(0, s);
          else m_inc(1, s);
          m_dir = cw;
          m_hist = {m_hist[HW-2:0], cw};
          if (m_tally < 2) m_tally++;
          if (fs) begin m_flut = 1'b1; s[7] = 1'b1; end
          if (fe) begin m_flut = 1'b0; s[6] = 1'b1; end
        end
      end
      default: ;
    endcase
    m_flags = (m_flags & ~cmask) | s;
    m_lv = nl;
  endtask

  task automatic cmp_all(input string req);
    chk({req, " cnt0"}, 32'(cnt0), 32'(m_c0));
    chk({req, " cnt1"}, 32'(cnt1), 32'(m_c1));
    chk({req, " flags"}, 32'(flags), 32'(m_flags));
    chk({req, " irq"}, 32'(irq), 32'(|(m_flags & en)));
    chk({req, " state"}, 32'(state), 32'(ph(m_lv)));
    chk({req, " dir"}, 32'(dir), 32'(m_dir));
    chk({req, " hist"}, 32'(hist), 32'(m_hist));
    chk({req, " flutter"}, 32'(flut), 32'(m_flut));
  endtask

  task automatic apply(input logic [1:0] nl, input string req);
    logic [1:0] old;
    old = m_lv;
    @(negedge clk);
    ch = nl;
    model(nl, 8'h00);
    @(negedge clk);
    chk("R14 lvl", 32'(lvl), 32'(nl));
    chk("R14 lvl_prev", 32'(lvl_prev), 32'(old));
    @(negedge clk);
    cmp_all(req);
  endtask

  task automatic set_mode(input logic [1:0] md);
    @(negedge clk);
    mode = md;
    @(negedge clk);
    @(negedge clk);
    if (md != 2'd3) begin m_flut = 1'b0; m_tally = 0; end
  endtask

  task automatic clear(input logic [7:0] mask);
    @(negedge clk);
    clr = mask;
    @(negedge clk);
    clr = 8'h00;
    m_flags = m_flags & ~mask;
    @(negedge clk);
    cmp_all("R13 clear");
  endtask

  function automatic logic [1:0] qstep(input logic [1:0] l, input bit fwd);
    qstep = lv_of(fwd ? ph(l) + 2'd1 : ph(l) - 2'd1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R14 reset");

    // R1: off mode ignores channel activity
    en = 8'hFF;
    for (int i = 0; i < 8; i++) apply(2'($urandom), "R1");

    // R2 and R11: single mode, match at 3
    cmp0 = 10'd3;
    set_mode(2'd1);
    for (int i = 0; i < 10; i++) apply(m_lv ^ 2'b01 ^ 2'($urandom % 2 * 2), "R2");

    // R13: clear, then clear colliding with a new set
    en = 8'h14;
    clear(8'hFF);
    @(negedge clk);
    ch = m_lv ^ 2'b01;
    @(negedge clk);
    clr = 8'h10;
    model(ch, 8'h10);
    @(negedge clk);
    clr = 8'h00;
    cmp_all("R13 set wins");
    clear(8'hFF);

    // R3 and R12: dual mode random levels
    cmp1 = 10'd4;
    set_mode(2'd2);
    for (int i = 0; i < 30; i++) apply(2'($urandom), "R3");
    apply(m_lv ^ 2'b10, "R12");
    clear(8'hFF);

    // R4, R5, R6: quadrature directed
    set_mode(2'd3);
    for (int i = 0; i < 6; i++) apply(qstep(m_lv, 1'b1), "R4");
    for (int i = 0; i < 4; i++) apply(qstep(m_lv, 1'b0), "R5");
    apply(~m_lv, "R6");
    apply(~m_lv, "R6");

    // R7, R8: flutter with freeze
    stop_en = 1'b1;
    apply(qstep(m_lv, 1'b1), "R7");
    apply(qstep(m_lv, 1'b1), "R7");
    apply(qstep(m_lv, 1'b0), "R7");
    apply(qstep(m_lv, 1'b1), "R7");
    chk("R7 flutter start", 32'(flut), 32'd1);
    apply(qstep(m_lv, 1'b0), "R8");
    apply(qstep(m_lv, 1'b1), "R8");
    apply(qstep(m_lv, 1'b1), "R7");
    chk("R7 flutter end", 32'(flut), 32'd0);
    clear(8'hFF);

    // R9: random quadrature with dual fallback
    stop_en = 1'b0;
    dual_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) apply(~m_lv, "R9");
      else if (r < 6) apply(qstep(m_lv, 1'b1), "R9");
      else apply(qstep(m_lv, 1'b0), "R9");
    end
    for (int i = 0; i < 300; i++) apply(qstep(m_lv, $urandom % 3 != 0), "R7");
    clear(8'hFF);

    // R10: wrap in single mode
    set_mode(2'd1);
    cmp0 = 10'd5;
    for (int i = 0; i < 2100; i++) apply(m_lv ^ 2'b01, "R10");
    chk("R10 wrapped flag", 32'(flags[1]), 32'd1);

    // R1: back to off, changes ignored
    clear(8'hFF);
    set_mode(2'd0);
    for (int i = 0; i < 6; i++) apply(2'($urandom), "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule